// File: doc/BRIEF.md
# Interrupt Control and Flag Register

This block is the core interrupt control register of a small microcontroller. One 8-bit word holds two gates and three enables for the interrupt sources, plus three sticky event flags. The sources are a timer overflow, an external pin edge and a port-change detector. Hardware event pulses set the flags, and software reads the word and may rewrite any bit. The block drives one combined interrupt request toward the core.

A flag latches its event whatever the enables are, so software can poll events with interrupts masked. The port-change flag also has a hold input from its detector. While a mismatch is present, the flag is set again on every clock, so a clear written by software does not take effect until the mismatch has been resolved. A pending-request line from the peripheral interrupt registers elsewhere in the chip passes through the peripheral gate. Priority arbitration, vectoring and the event detectors themselves live outside this block.

The reset input asserts asynchronously. Its release is synchronised through two flops, so the register leaves reset two clock edges after `rst_n` rises.

Top module: `intc_ctl_reg`

## Requirements
- R1: Bit 7 is the global gate and bit 6 is the peripheral gate. Bits 5, 4 and 3 enable the timer, external-pin and port-change sources. Bits 2, 1 and 0 are the timer, external-pin and port-change flags. A cycle with `wr_en` high loads all eight bits from `wr_data`, including the reserved external-pin enable, and `rd_data` returns the register.
- R2: A high on `ev_pulse[i]` (index 0 = port-change, 1 = external pin, 2 = timer) sets flag bit i at the next clock edge, whatever the values of the enables and gates.
- R3: A set flag stays set until software writes a 0 to it. Hardware never clears a flag.
- R4: When an event and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R5: While `mismatch` is high, the port-change flag (bit 0) is set on every clock edge, so a written 0 does not persist. Once `mismatch` is low, a written 0 holds.
- R6: `irq` is 1 only when bit 7 is 1 and either some flag is 1 together with its own enable, or the peripheral term of R7 is active. When bit 7 is 0, `irq` is 0.
- R7: The `per_pend` input contributes to `irq` only while bit 6 is 1.
- R8: Asserting `rst_n` low clears the whole register at once, without waiting for a clock. The port-change flag resets to the `PC_FLAG_RST` parameter, whose default is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| wr_en | input | 1 | Software write strobe for the whole register |
| wr_data | input | 8 | Write value, laid out as in R1 |
| per_pend | input | 1 | Combined pending request from the peripheral interrupt registers |
| ev_pulse | input | 3 | Event pulses: [0] port-change, [1] external pin, [2] timer overflow |
| mismatch | input | 1 | Port-change mismatch still present |
| rd_data | output | 8 | Current register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: three sources, an 8-bit word and a port-change reset value of 0. That configuration is small enough to cover every one of the 256 write values against every event pattern, with `mismatch` both low and high. The sweep therefore reaches every enable/flag/gate combination that feeds `irq`, and every collision between a written 0 and an event. A hold cycle after each write shows the flags stay sticky. Directed sequences cover a clear written while a mismatch persists, and an asynchronous reset asserted between clock edges.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // Source indices inside the flag and enable fields
  typedef enum int unsigned {
    SRC_PORT = 0,
    SRC_EXT  = 1,
    SRC_TMR  = 2
  } intc_src_e;

  localparam int unsigned INTC_N_SRC_DEF = 3;

  // Register width for a given number of sources: two gates plus enable and flag per source
  function automatic int unsigned intc_width(input int unsigned n_src);
    return 2 + 2 * n_src;
  endfunction

endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_gie,
  input  logic             wr_peie,
  input  logic [N_SRC-1:0] wr_src_en,
  output logic             gie,
  output logic             peie,
  output logic [N_SRC-1:0] src_en
);

  logic             gie_d, peie_d;
  logic [N_SRC-1:0] src_en_d;
  logic             ce;

  always_comb begin
    ce       = wr_en;
    gie_d    = wr_gie;
    peie_d   = wr_peie;
    src_en_d = wr_src_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie    <= 1'b0;
      peie   <= 1'b0;
      src_en <= '0;
    end else if (ce) begin
      gie    <= gie_d;
      peie   <= peie_d;
      src_en <= src_en_d;
    end
  end

endmodule

// File: rtl/intc_flag_bank.sv
module intc_flag_bank #(
  parameter int unsigned     N_SRC    = 3,
  parameter int unsigned     HOLD_IDX = 0,
  parameter logic [N_SRC-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_SRC-1:0] wr_flags,
  input  logic [N_SRC-1:0] ev,
  input  logic             hold,
  output logic [N_SRC-1:0] flags
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_flag
    logic set_req;
    logic ce;
    logic flag_d;
    logic flag_q;

    if (i == HOLD_IDX) begin : g_hold
      assign set_req = ev[i] | hold;
    end else begin : g_plain
      assign set_req = ev[i];
    end

    // set has priority over the software value
    always_comb begin
      ce     = set_req | wr_en;
      flag_d = set_req ? 1'b1 : wr_flags[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q <= RST_VAL[i];
      else if (ce) flag_q <= flag_d;
    end

    assign flags[i] = flag_q;
  end

endmodule

// File: rtl/intc_req_gate.sv
module intc_req_gate #(
  parameter int unsigned N_SRC = 3
) (
  input  logic             gie,
  input  logic             peie,
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] flags,
  input  logic             per_pend,
  output logic             irq
);

  logic core_hit;
  logic per_hit;

  always_comb begin
    core_hit = |(src_en & flags);
    per_hit  = peie & per_pend;
    irq      = gie & (core_hit | per_hit);
  end

endmodule

// File: rtl/intc_ctl_reg.sv
module intc_ctl_reg #(
  parameter int unsigned      N_SRC       = intc_pkg::INTC_N_SRC_DEF,
  parameter logic             PC_FLAG_RST = 1'b0,
  localparam int unsigned     W           = intc_pkg::intc_width(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             per_pend,
  input  logic [N_SRC-1:0] ev_pulse,
  input  logic             mismatch,
  output logic [W-1:0]     rd_data,
  output logic             irq
);

  localparam int unsigned BIT_GIE  = W - 1;
  localparam int unsigned BIT_PEIE = W - 2;
  localparam int unsigned EN_LO    = N_SRC;
  localparam int unsigned PC_IDX   = int'(intc_pkg::SRC_PORT);
  localparam logic [N_SRC-1:0] FLAG_RST = {{(N_SRC-1){1'b0}}, PC_FLAG_RST};

  logic             rst_int_n;
  logic             gie, peie;
  logic [N_SRC-1:0] src_en;
  logic [N_SRC-1:0] flags;

  intc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  intc_enable_bank #(.N_SRC(N_SRC)) u_en (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_gie    (wr_data[BIT_GIE]),
    .wr_peie   (wr_data[BIT_PEIE]),
    .wr_src_en (wr_data[EN_LO +: N_SRC]),
    .gie       (gie),
    .peie      (peie),
    .src_en    (src_en)
  );

  intc_flag_bank #(
    .N_SRC    (N_SRC),
    .HOLD_IDX (PC_IDX),
    .RST_VAL  (FLAG_RST)
  ) u_flag (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_flags (wr_data[N_SRC-1:0]),
    .ev       (ev_pulse),
    .hold     (mismatch),
    .flags    (flags)
  );

  intc_req_gate #(.N_SRC(N_SRC)) u_gate (
    .gie      (gie),
    .peie     (peie),
    .src_en   (src_en),
    .flags    (flags),
    .per_pend (per_pend),
    .irq      (irq)
  );

  assign rd_data = {gie, peie, src_en, flags};

endmodule

// File: rtl/intc_ctl_reg_chk.sv
module intc_ctl_reg_chk #(
  parameter int unsigned  N_SRC = 3,
  localparam int unsigned W     = 2 + 2 * N_SRC
) (
  input logic             clk,
  input logic             rst_ok_n,
  input logic             wr_en,
  input logic [W-1:0]     wr_data,
  input logic             per_pend,
  input logic [N_SRC-1:0] ev_pulse,
  input logic             mismatch,
  input logic [W-1:0]     rd_data,
  input logic             irq
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
      ev_pulse[i] |=> rd_data[i]);

    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (rd_data[i] && !(wr_en && !wr_data[i])) |=> rd_data[i]);

    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_ok_n)
      (wr_en && !wr_data[i] && ev_pulse[i]) |=> rd_data[i]);
  end

  assert_write_load_R1: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en && ev_pulse == '0 && !mismatch) |=> rd_data == $past(wr_data));

  assert_mismatch_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mismatch |=> rd_data[0]);

  assert_global_mask_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rd_data[W-1] |-> !irq);

  assert_periph_gate_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!rd_data[W-2] && ((rd_data[N_SRC-1:0] & rd_data[2*N_SRC-1:N_SRC]) == '0)) |-> !irq);

  assert_periph_pass_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (rd_data[W-1] && rd_data[W-2] && per_pend) |-> irq);

endmodule

bind intc_ctl_reg intc_ctl_reg_chk #(.N_SRC(N_SRC)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_int_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .per_pend (per_pend),
  .ev_pulse (ev_pulse),
  .mismatch (mismatch),
  .rd_data  (rd_data),
  .irq      (irq)
);

// File: tb/intc_ctl_reg_tb.sv
module intc_ctl_reg_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       per_pend;
  logic [2:0] ev_pulse;
  logic       mismatch;
  logic [7:0] rd_data;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_ctl_reg u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .per_pend (per_pend),
    .ev_pulse (ev_pulse),
    .mismatch (mismatch),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  function automatic logic exp_irq(input logic [7:0] m, input logic pp);
    logic hit;
    hit = |(m[2:0] & m[5:3]);
    return m[7] & (hit | (m[6] & pp));
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] wd, input logic [2:0] ev,
                      input logic mis, input logic pp, input string rtag);
    string itag;
    wr_en    = we;
    wr_data  = wd;
    ev_pulse = ev;
    mismatch = mis;
    per_pend = pp;
    @(posedge clk);
    if (we) model = wd;
    model[2:0] = model[2:0] | ev;
    if (mis) model[0] = 1'b1;
    @(negedge clk);
    check(rtag, rd_data, model);
    itag = (!model[7] || (|(model[2:0] & model[5:3]))) ? "R6" : "R7";
    check(itag, {7'd0, irq}, {7'd0, exp_irq(model, pp)});
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_data  = '0;
    per_pend = 1'b0;
    ev_pulse = '0;
    mismatch = 1'b0;
    model    = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", rd_data, 8'h00);
    check("R8", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", rd_data, 8'h00);

    // Sweep all write values x event patterns x mismatch
    for (int v = 0; v < 256; v++) begin
      for (int e = 0; e < 8; e++) begin
        for (int m = 0; m < 2; m++) begin
          logic [7:0] wv;
          logic [2:0] ev;
          string tag;
          wv = 8'(v);
          ev = 3'(e);
          if (m != 0)                        tag = "R5";
          else if ((ev & ~wv[2:0]) != 3'b0)  tag = "R4";
          else if (ev != 3'b0)               tag = "R2";
          else                               tag = "R1";
          step(1'b1, wv, ev, m[0], wv[0] ^ ev[1], tag);
          // R3: flags persist with no write and no event
          step(1'b0, 8'h00, 3'b000, 1'b0, ev[0], "R3");
        end
      end
    end

    // R2: events set flags with all enables and gates off
    step(1'b1, 8'h00, 3'b000, 1'b0, 1'b0, "R1");
    step(1'b0, 8'h00, 3'b101, 1'b0, 1'b1, "R2");
    check("R2", rd_data, 8'h05);

    // R5: clear does not hold while mismatch persists
    step(1'b1, 8'h00, 3'b000, 1'b1, 1'b0, "R5");
    step(1'b1, 8'h00, 3'b000, 1'b1, 1'b0, "R5");
    check("R5", {7'd0, rd_data[0]}, 8'h01);
    step(1'b0, 8'h00, 3'b000, 1'b0, 1'b0, "R5");
    step(1'b1, 8'h00, 3'b000, 1'b0, 1'b0, "R5");
    check("R5", {7'd0, rd_data[0]}, 8'h00);

    // R6/R7: gates with peripheral request
    step(1'b1, 8'h40, 3'b000, 1'b0, 1'b1, "R1");
    check("R6", {7'd0, irq}, 8'h00);
    step(1'b1, 8'hC0, 3'b000, 1'b0, 1'b1, "R1");
    check("R7", {7'd0, irq}, 8'h01);
    step(1'b1, 8'h80, 3'b000, 1'b0, 1'b1, "R1");
    check("R7", {7'd0, irq}, 8'h00);

    // R8: asynchronous reset between edges
    step(1'b1, 8'hFF, 3'b000, 1'b0, 1'b0, "R1");
    wr_en = 1'b0;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R8", rd_data, 8'h00);
    check("R8", {7'd0, irq}, 8'h00);

    summary();
    $finish;
  end

endmodule